// File: doc/BRIEF.md
# Smart Card Half-Duplex Character Transceiver

This block moves single characters over a one-wire smart-card style link in one direction at a time. Every bit lasts a fixed number of base clock periods (372 by default). The base clock is a divided version of the system clock, and the block can also drive it out to the card. A character is a low start bit, eight data bits with the least significant bit first, and a parity bit. Parity is always used, and a mode input picks odd or even.

The receiver waits for a falling edge on the incoming line. The edge restarts its bit timer, so every character is timed from its own start. Each bit is sampled once, when the in-bit count reaches its sample point at mid-bit. The receiver then checks parity and reports the result through a receive-full flag, a parity-error flag and an overrun flag. Each flag stays set until its own clear strobe. While parity-error or overrun is set, no new character is taken in.

The transmitter loads a byte on a start strobe and shifts out the character. It drives the output enable only while a character is on the line. A transmit-end flag rises one full bit period after the parity bit begins. Transmit and receive are mutually exclusive. With both enabled, the block stays idle unless the loopback input is set; in that case the receiver listens to the transmitter.

Top module: `sc_xcvr`

## Requirements
- R1: With P = BIT_CLKS*CLK_DIV clock cycles per bit, a tx_start taken at clock edge S (transmitter idle and active) drives tx_line as follows: 0 from S, data bit i (LSB first) from S+(i+1)*P, parity from S+9*P, and high again from S+10*P. When not sending, tx_line is high.
- R2: The parity bit is chosen so that the data bits plus parity hold an even number of ones when odd_par=0, and an odd number when odd_par=1.
- R3: tx_oe is high from edge S until edge S+10*P. At S+10*P it falls and tx_end rises. tx_end clears at S. After reset, tx_end=1, tx_oe=0 and tx_line=1.
- R4: The receiver passes rx_line through a two-stage synchronizer. It starts a character on a falling edge and restarts its bit count at 0. It samples each bit at count SAMPLE_AT. If rx_line first goes low just after edge n, then rx_full, rx_data (LSB first) and the error flags update at edge n+3+(9*BIT_CLKS+SAMPLE_AT+1)*CLK_DIV.
- R5: If the start bit reads high at its sample point, the receiver drops the character with no flag change and waits for the next falling edge.
- R6: A parity mismatch sets par_err. The data is still stored and rx_full is set.
- R7: If a character completes while rx_full is set, overrun is set, and rx_data and par_err are left unchanged.
- R8: rx_full, par_err and overrun stay set until a one-cycle pulse on clr_full, clr_par_err or clr_overrun. Each pulse clears its own flag at the following edge.
- R9: While par_err or overrun is set, the receiver does not start on a falling edge, so a whole character on rx_line leaves all flags and rx_data unchanged.
- R10: With tx_en and rx_en both high and loopback low, or with if_en low, tx_start is ignored (tx_oe stays low, tx_line high) and incoming characters are ignored.
- R11: With if_en, tx_en, rx_en and loopback all high, the receiver takes its input from tx_line, and a transmitted byte appears in rx_data with rx_full set.
- R12: When clk_out_en is high, card_clk is a square wave with a period of CLK_DIV cycles. One cycle after clk_out_en goes low, card_clk is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable; when low, both directions are idle |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| loopback | input | 1 | Self-test: allows both directions and routes tx_line into the receiver |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| clk_out_en | input | 1 | Drives the base clock out on card_clk |
| tx_start | input | 1 | One-cycle strobe that loads tx_data |
| tx_data | input | DATA_BITS | Byte to send |
| rx_line | input | 1 | Incoming serial line |
| clr_full | input | 1 | Clears rx_full |
| clr_par_err | input | 1 | Clears par_err |
| clr_overrun | input | 1 | Clears overrun |
| tx_line | output | 1 | Outgoing serial line value |
| tx_oe | output | 1 | High while the transmitter drives the line |
| card_clk | output | 1 | Base clock sent to the card |
| tx_end | output | 1 | Transmission complete |
| rx_data | output | DATA_BITS | Last received byte |
| rx_full | output | 1 | Received byte is waiting |
| par_err | output | 1 | Parity error flag |
| overrun | output | 1 | Overrun flag |

## Verification
A reference model predicts every output on every clock. The transmit path is driven with two bytes of different bit density, in even and then odd parity mode; this separates the LSB-first order from the parity sense and from the exact edges of each bit slot. The receive path gets a clean byte, a byte with flipped parity, a full character sent while an error flag is set, two back-to-back bytes for overrun, and a short low pulse before a valid byte; these tell apart the sample point, the error latching, the error blocking and the glitch rejection. A final pass with both directions enabled, first without and then with loopback, shows the difference between the idle conflict state and self-test.

// File: rtl/sc_pkg.sv
package sc_pkg;
    // Per-direction sequencing state
    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_RUN  = 1'b1
    } link_state_e;

    // Parity bit that completes a running XOR to the selected sense
    function automatic logic parity_fill(input logic running_xor, input logic odd_mode);
        return running_xor ^ odd_mode;
    endfunction
endpackage

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
    parameter int unsigned CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic card_clk
);
    localparam int unsigned SW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [SW-1:0] PH_LAST = SW'(CLK_DIV - 1);
    localparam logic [SW-1:0] PH_HALF = SW'(CLK_DIV / 2);

    typedef struct packed {
        logic [SW-1:0] phase;
        logic          ck;
    } cg_t;

    cg_t q, d;

    always_comb begin
        d = q;
        d.phase = (q.phase == PH_LAST) ? '0 : q.phase + 1'b1;
        d.ck    = en && (d.phase < PH_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign card_clk = q.ck;

    // R12: output held low once the enable is removed
    p_clk_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !card_clk);
endmodule

// File: rtl/sc_tx.sv
module sc_tx import sc_pkg::*; #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned BIT_CLKS  = 372,
    parameter int unsigned CLK_DIV   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 odd_par,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] data,
    output logic                 line,
    output logic                 oe,
    output logic                 done,
    output logic                 busy
);
    localparam int unsigned SW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned CW = $clog2(BIT_CLKS);
    localparam int unsigned IW = $clog2(DATA_BITS + 2);
    localparam logic [SW-1:0] SUB_LAST = SW'(CLK_DIV - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CLKS - 1);
    localparam logic [IW-1:0] IDX_LASTD = IW'(DATA_BITS);
    localparam logic [IW-1:0] IDX_PAR  = IW'(DATA_BITS + 1);

    typedef struct packed {
        link_state_e          st;
        logic [SW-1:0]        sub;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 par;
        logic                 line;
        logic                 oe;
        logic                 done;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            LINK_IDLE: begin
                if (active && start) begin
                    d.st    = LINK_RUN;
                    d.sub   = '0;
                    d.cnt   = '0;
                    d.idx   = '0;
                    d.shreg = data;
                    d.par   = parity_fill(^data, odd_par);
                    d.line  = 1'b0;
                    d.oe    = 1'b1;
                    d.done  = 1'b0;
                end
            end
            default: begin
                if (!active) begin
                    d.st   = LINK_IDLE;
                    d.line = 1'b1;
                    d.oe   = 1'b0;
                end else if (q.sub != SUB_LAST) begin
                    d.sub = q.sub + 1'b1;
                end else begin
                    d.sub = '0;
                    if (q.cnt != CNT_LAST) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                        if (q.idx == IDX_PAR) begin
                            d.st   = LINK_IDLE;
                            d.line = 1'b1;
                            d.oe   = 1'b0;
                            d.done = 1'b1;
                        end else if (q.idx == IDX_LASTD) begin
                            d.line = q.par;
                        end else begin
                            d.line  = q.shreg[0];
                            d.shreg = q.shreg >> 1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: LINK_IDLE, line: 1'b1, done: 1'b1, default: '0};
        else        q <= d;
    end

    assign line = q.line;
    assign oe   = q.oe;
    assign done = q.done;
    assign busy = (q.st == LINK_RUN);

    // R1: line rests high whenever it is not being driven
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> line);
    // R3: completion coincides with release of the line
    p_end_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !oe);
endmodule

// File: rtl/sc_rx.sv
module sc_rx import sc_pkg::*; #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned BIT_CLKS  = 372,
    parameter int unsigned SAMPLE_AT = 185,
    parameter int unsigned CLK_DIV   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 odd_par,
    input  logic                 line_in,
    input  logic                 clr_full,
    input  logic                 clr_par,
    input  logic                 clr_ovr,
    output logic [DATA_BITS-1:0] data,
    output logic                 full,
    output logic                 perr,
    output logic                 ovr,
    output logic                 busy
);
    localparam int unsigned SW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned CW = $clog2(BIT_CLKS);
    localparam int unsigned IW = $clog2(DATA_BITS + 2);
    localparam logic [SW-1:0] SUB_LAST   = SW'(CLK_DIV - 1);
    localparam logic [CW-1:0] CNT_LAST   = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] CNT_SAMPLE = CW'(SAMPLE_AT);
    localparam logic [IW-1:0] IDX_PAR    = IW'(DATA_BITS + 1);

    typedef struct packed {
        link_state_e          st;
        logic                 s1;
        logic                 s2;
        logic                 s3;
        logic [SW-1:0]        sub;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 acc;
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 perr;
        logic                 ovr;
    } rx_t;

    rx_t  q, d;
    logic fall_seen;
    logic bit_val;

    always_comb begin
        d         = q;
        d.s1      = line_in;
        d.s2      = q.s1;
        d.s3      = q.s2;
        fall_seen = q.s3 && !q.s2;
        bit_val   = q.s2;
        if (clr_full) d.full = 1'b0;
        if (clr_par)  d.perr = 1'b0;
        if (clr_ovr)  d.ovr  = 1'b0;
        unique case (q.st)
            LINK_IDLE: begin
                if (active && !q.perr && !q.ovr && fall_seen) begin
                    d.st  = LINK_RUN;
                    d.sub = '0;
                    d.cnt = '0;
                    d.idx = '0;
                    d.acc = 1'b0;
                end
            end
            default: begin
                if (!active) begin
                    d.st = LINK_IDLE;
                end else if (q.sub != SUB_LAST) begin
                    d.sub = q.sub + 1'b1;
                end else begin
                    d.sub = '0;
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (q.cnt == CNT_SAMPLE) begin
                        if (q.idx == '0) begin
                            if (bit_val) d.st = LINK_IDLE;
                        end else if (q.idx != IDX_PAR) begin
                            d.shreg = {bit_val, q.shreg[DATA_BITS-1:1]};
                            d.acc   = q.acc ^ bit_val;
                        end else begin
                            d.st = LINK_IDLE;
                            if (q.full) begin
                                d.ovr = 1'b1;
                            end else begin
                                d.data = q.shreg;
                                d.full = 1'b1;
                                if (bit_val != parity_fill(q.acc, odd_par)) d.perr = 1'b1;
                            end
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: LINK_IDLE, s1: 1'b1, s2: 1'b1, s3: 1'b1, default: '0};
        else        q <= d;
    end

    assign data = q.data;
    assign full = q.full;
    assign perr = q.perr;
    assign ovr  = q.ovr;
    assign busy = (q.st == LINK_RUN);

    // R7: overrun leaves stored byte untouched
    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(data));
    // R8: parity error persists without its clear strobe
    p_perr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        perr && !clr_par |=> perr);
    // R9: a pending error keeps the receiver idle
    p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (perr || ovr) && !busy |=> !busy);
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned BIT_CLKS  = 372,
    parameter int unsigned SAMPLE_AT = 185,
    parameter int unsigned CLK_DIV   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 if_en,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 loopback,
    input  logic                 odd_par,
    input  logic                 clk_out_en,
    input  logic                 tx_start,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 rx_line,
    input  logic                 clr_full,
    input  logic                 clr_par_err,
    input  logic                 clr_overrun,
    output logic                 tx_line,
    output logic                 tx_oe,
    output logic                 card_clk,
    output logic                 tx_end,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 par_err,
    output logic                 overrun
);
    logic tx_go, rx_go, rx_src, tx_busy, rx_busy, tx_line_w;

    // One direction at a time unless self-test loopback is requested
    assign tx_go  = if_en && tx_en && (!rx_en || loopback);
    assign rx_go  = if_en && rx_en && (!tx_en || loopback);
    assign rx_src = loopback ? tx_line_w : rx_line;

    sc_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_out_en),
        .card_clk (card_clk)
    );

    sc_tx #(.DATA_BITS(DATA_BITS), .BIT_CLKS(BIT_CLKS), .CLK_DIV(CLK_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tx_go),
        .odd_par (odd_par),
        .start   (tx_start),
        .data    (tx_data),
        .line    (tx_line_w),
        .oe      (tx_oe),
        .done    (tx_end),
        .busy    (tx_busy)
    );

    sc_rx #(.DATA_BITS(DATA_BITS), .BIT_CLKS(BIT_CLKS), .SAMPLE_AT(SAMPLE_AT),
            .CLK_DIV(CLK_DIV)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (rx_go),
        .odd_par  (odd_par),
        .line_in  (rx_src),
        .clr_full (clr_full),
        .clr_par  (clr_par_err),
        .clr_ovr  (clr_overrun),
        .data     (rx_data),
        .full     (rx_full),
        .perr     (par_err),
        .ovr      (overrun),
        .busy     (rx_busy)
    );

    assign tx_line = tx_line_w;

    // R10: both sequencers run together only under loopback
    p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && rx_busy |-> $past(loopback));
endmodule

// File: tb/sc_xcvr_tb.sv
module sc_xcvr_tb;
    localparam int  BIT = 372;
    localparam int  SMP = 185;
    localparam int  DIV = 2;
    localparam int  P   = BIT * DIV;
    localparam longint RX_LAT = 3 + (9 * BIT + SMP + 1) * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_en = 1'b1, tx_en = 1'b0, rx_en = 1'b0, loopback = 1'b0, odd_par = 1'b0;
    logic clk_out_en = 1'b0, tx_start = 1'b0, rx_line = 1'b1;
    logic clr_full = 1'b0, clr_par_err = 1'b0, clr_overrun = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_line, tx_oe, card_clk, tx_end, rx_full, par_err, overrun;
    logic [7:0] rx_data;

    always #2.5 clk = ~clk;

    sc_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .tx_en(tx_en), .rx_en(rx_en),
        .loopback(loopback), .odd_par(odd_par), .clk_out_en(clk_out_en),
        .tx_start(tx_start), .tx_data(tx_data), .rx_line(rx_line),
        .clr_full(clr_full), .clr_par_err(clr_par_err), .clr_overrun(clr_overrun),
        .tx_line(tx_line), .tx_oe(tx_oe), .card_clk(card_clk), .tx_end(tx_end),
        .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err), .overrun(overrun)
    );

    typedef struct { longint at; int sig; int val; } ev_t;
    ev_t    evq[$];
    longint cyc = 0;
    int     nvec = 0, nmis = 0;
    int     exp_v[7] = '{1, 0, 1, 0, 0, 0, 0};
    string  tag_of[7] = '{"R1", "R3", "R3", "R4", "R4", "R6", "R7"};
    string  name_of[7] = '{"tx_line", "tx_oe", "tx_end", "rx_full", "rx_data", "par_err", "overrun"};
    bit     m_full = 0, m_perr = 0, m_ovr = 0;
    bit     finished = 0;

    function automatic void sched(longint at, int sig, int val);
        ev_t e;
        e.at = at; e.sig = sig; e.val = val;
        evq.push_back(e);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = evq.size() - 1; i >= 0; i--) begin
            if (evq[i].at == cyc + 1) begin
                exp_v[evq[i].sig] = evq[i].val;
                evq.delete(i);
            end
        end
    end

    // Clock-by-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int act[7];
            act[0] = int'(tx_line); act[1] = int'(tx_oe); act[2] = int'(tx_end);
            act[3] = int'(rx_full); act[4] = int'(rx_data); act[5] = int'(par_err);
            act[6] = int'(overrun);
            nvec++;
            for (int s = 0; s < 7; s++) begin
                if (act[s] !== exp_v[s]) begin
                    nmis++;
                    $display("FAIL %s %s at cycle %0d: got %0h expected %0h",
                             tag_of[s], name_of[s], cyc, act[s], exp_v[s]);
                end
            end
        end
    end

    task automatic chk(string tag, string what, longint act, longint expv);
        nvec++;
        if (act != expv) begin
            nmis++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic wait_until(longint t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic send_tx(logic [7:0] dv, bit act_tx, bit loop_rx);
        longint S;
        logic par;
        @(negedge clk);
        tx_data  = dv;
        tx_start = 1'b1;
        S   = cyc + 1;
        par = ^dv ^ odd_par;
        if (act_tx) begin
            sched(S, 0, 0); sched(S, 1, 1); sched(S, 2, 0);
            for (int k = 1; k <= 8; k++) sched(S + k * P, 0, int'(dv[k-1]));
            sched(S + 9 * P, 0, int'(par));
            sched(S + 10 * P, 0, 1); sched(S + 10 * P, 1, 0); sched(S + 10 * P, 2, 1);
            if (loop_rx) begin
                sched(S + RX_LAT, 3, 1); sched(S + RX_LAT, 4, int'(dv));
                m_full = 1;
            end
        end
        @(negedge clk);
        tx_start = 1'b0;
        wait_until(S + 9 * P + P / 2);
        if (act_tx) chk("R2", "parity bit on line", tx_line, par);
        else        chk("R10", "line during blocked start", {tx_oe, tx_line}, 2'b01);
        wait_until(S + 10 * P + 10);
    endtask

    task automatic send_rx(logic [7:0] dv, bit bad, bit act_rx);
        longint n, C;
        logic p;
        p = ^dv ^ odd_par ^ bad;
        @(negedge clk);
        rx_line = 1'b0;
        n = cyc;
        C = n + RX_LAT;
        if (act_rx && !m_perr && !m_ovr) begin
            if (m_full) begin
                sched(C, 6, 1); m_ovr = 1;
            end else begin
                sched(C, 3, 1); sched(C, 4, int'(dv)); m_full = 1;
                if (bad) begin sched(C, 5, 1); m_perr = 1; end
            end
        end
        for (int k = 0; k < 8; k++) begin
            repeat (P) @(negedge clk);
            rx_line = dv[k];
        end
        repeat (P) @(negedge clk);
        rx_line = p;
        repeat (P) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_clr(int which);
        @(negedge clk);
        if (which == 3) begin clr_full = 1'b1; m_full = 0; end
        if (which == 5) begin clr_par_err = 1'b1; m_perr = 0; end
        if (which == 6) begin clr_overrun = 1'b1; m_ovr = 0; end
        sched(cyc + 1, which, 0);
        @(negedge clk);
        clr_full = 1'b0; clr_par_err = 1'b0; clr_overrun = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nmis++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        int rises;
        logic prev;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3, R4)
        chk("R3", "reset tx_end/tx_oe/tx_line", {tx_end, tx_oe, tx_line}, 3'b101);
        chk("R4", "reset rx_full", rx_full, 0);

        // R12: card clock output
        clk_out_en = 1'b1;
        repeat (10) @(negedge clk);
        rises = 0; prev = card_clk;
        repeat (200) begin @(negedge clk); if (card_clk && !prev) rises++; prev = card_clk; end
        chk("R12", "card_clk rises in 200 cycles", rises, 200 / DIV);
        clk_out_en = 1'b0;
        repeat (3) @(negedge clk);
        rises = 0;
        repeat (50) begin @(negedge clk); if (card_clk) rises++; end
        chk("R12", "card_clk high cycles while disabled", rises, 0);

        // R1/R2/R3: transmit in both parity modes
        tx_en = 1'b1;
        odd_par = 1'b0; send_tx(8'hA5, 1, 0);
        odd_par = 1'b1; send_tx(8'h3C, 1, 0);
        chk("R3", "tx_end after character", tx_end, 1);

        // R4: clean reception, even parity
        tx_en = 1'b0; rx_en = 1'b1; odd_par = 1'b0;
        send_rx(8'h5A, 0, 1);
        chk("R4", "received byte", rx_data, 8'h5A);
        pulse_clr(3);

        // R6: parity error keeps data
        send_rx(8'h81, 1, 1);
        chk("R6", "par_err and rx_full", {par_err, rx_full}, 2'b11);
        pulse_clr(3);

        // R9: receiver blocked while par_err is set
        send_rx(8'hFF, 0, 1);
        chk("R9", "rx_full while blocked", rx_full, 0);
        chk("R8", "par_err persists", par_err, 1);
        pulse_clr(5);
        @(negedge clk);
        chk("R8", "par_err after clear", par_err, 0);

        // R7: overrun keeps the earlier byte
        send_rx(8'h11, 0, 1);
        send_rx(8'h22, 0, 1);
        chk("R7", "overrun set, data kept", {overrun, rx_data}, {1'b1, 8'h11});
        pulse_clr(6);
        pulse_clr(3);

        // R5: short low pulse rejected, next byte accepted
        @(negedge clk);
        rx_line = 1'b0;
        repeat (100) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * P) @(negedge clk);
        chk("R5", "no flag after glitch", {rx_full, par_err, overrun}, 3'b000);
        odd_par = 1'b1;
        send_rx(8'h96, 0, 1);
        chk("R5", "byte after glitch", rx_data, 8'h96);
        pulse_clr(3);

        // R10: conflicting enables without loopback stay idle
        tx_en = 1'b1; rx_en = 1'b1;
        send_tx(8'h77, 0, 0);
        send_rx(8'h44, 0, 0);
        chk("R10", "rx_full with both enabled", rx_full, 0);
        if_en = 1'b0; tx_en = 1'b1; rx_en = 1'b0;
        send_tx(8'h0F, 0, 0);
        if_en = 1'b1;

        // R11: loopback self-test
        rx_en = 1'b1; loopback = 1'b1;
        send_tx(8'hC3, 1, 1);
        chk("R11", "loopback byte", {rx_full, rx_data}, {1'b1, 8'hC3});
        loopback = 1'b0; tx_en = 1'b0;
        repeat (5) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule